// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Tracker

This block is the per-CPU engine that turns acknowledge reads and end-of-interrupt writes into changes of the CPU's running interrupt. An acknowledge takes the highest-pending interrupt, which an external arbiter supplies, together with its priority and its distribution-model bit. The block accepts it only if its priority is strictly below the running priority. Otherwise it answers with the spurious ID 1023. An accepted interrupt becomes the running one. The block remembers the interrupt it displaced in a per-ID predecessor link, and it asks the state store to clear the pending bit.

An end-of-interrupt write names the completed ID in the low 10 bits of a 32-bit word. Completing the running interrupt makes its predecessor the running interrupt again. Completing an interrupt further down the nesting chain splices it out of the chain, so completions may come in any order. That splice walks the chain one link per clock, and `busy` is high while it runs. On completion of a level-sensitive interrupt that is still raised, the block sends a pending-set request back to the state store.

Top module: `irq_ack_tracker`

## Requirements
- R1: An accepted acknowledge answers 1023 and changes nothing when the offered ID is 1023, is not below NUM_IRQ, or has a priority not strictly below the running priority.
- R2: Otherwise the response carries the offered ID, and that ID becomes the running ID with its priority as the running priority. The response (`ack_vld` pulse with `ack_id`) appears on the clock edge after the request is accepted.
- R3: Whenever the running ID is 1023 the running priority is 0x100 (one above the largest 8-bit priority); both hold after reset.
- R4: A successful acknowledge pulses `clr_vld` in the same cycle as its response, with `clr_id` equal to the response ID and `clr_all` equal to the offered model bit (1 = clear for all CPUs, 0 = this CPU only).
- R5: An end-of-interrupt accepted while the running ID is 1023 has no effect: no pending-set request and no state change.
- R6: Completing the running ID restores the predecessor recorded when that ID was acknowledged, together with the priority the predecessor had when it was acknowledged (0x100 if the predecessor is 1023).
- R7: Completing an ID other than the running one leaves the running ID unchanged. If some link in the chain from the running ID points at the completed ID, that link takes over the completed ID's own predecessor. The walk stops at a link of 1023.
- R8: When the running ID is not 1023, an accepted end-of-interrupt with `eoi_repend` high and an ID below NUM_IRQ pulses `set_vld` with `set_id` equal to that ID on the next edge.
- R9: The completed ID is bits [9:0] of `eoi_wdata`; bits [31:10] are ignored.
- R10: A splice walk examines one link per clock and holds `busy` high for as many cycles as links examined. Requests that arrive while `busy` is high are dropped and produce no response.
- R11: If acknowledge and end-of-interrupt requests arrive together, the acknowledge is served and the completion is dropped.
- R12: After reset every predecessor link is 1023, so completing the first interrupt acknowledged after reset returns the running ID to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_id | input | 10 | Highest-pending ID from the arbiter (1023 = none) |
| hp_prio | input | PRIO_W | Priority of `hp_id` |
| hp_model | input | 1 | Distribution model of `hp_id` (1 = all CPUs) |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_wdata | input | 32 | End-of-interrupt write data; ID in [9:0] |
| eoi_repend | input | 1 | Completed ID is level-sensitive, enabled, raised and targeted here |
| busy | output | 1 | Splice walk in progress |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority |
| clr_vld | output | 1 | Pending-clear request |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for all CPUs (else this CPU only) |
| set_vld | output | 1 | Pending-set request for this CPU |
| set_id | output | 10 | ID to set pending |

## Verification
A corrupted predecessor link is not visible when it happens. It first shows up when completions unwind the chain: `run_id` and `run_prio` then land on the wrong interrupt, sometimes many acknowledges later. A corrupted priority shadow shows the same way, as a wrong `run_prio` after a restore. For that reason the bench builds deep chains, completes interrupts in scrambled order and always completes back down to 1023. A wrong walk cursor shows immediately, as a `busy` pulse of the wrong length.

// File: rtl/irq_ack_tracker.sv
`timescale 1ns/1ps
module irq_ack_tracker #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        hp_id,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic              hp_model,
  input  logic              ack_req,
  output logic              ack_vld,
  output logic [9:0]        ack_id,
  input  logic              eoi_req,
  input  logic [31:0]       eoi_wdata,
  input  logic              eoi_repend,
  output logic              busy,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio,
  output logic              clr_vld,
  output logic [9:0]        clr_id,
  output logic              clr_all,
  output logic              set_vld,
  output logic [9:0]        set_id
);
  localparam int           IW        = $clog2(NUM_IRQ);
  localparam logic [9:0]   NONE      = 10'h3FF;
  localparam logic [9:0]   NIRQ_ID   = 10'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [9:0]        link     [NUM_IRQ];
  logic [PRIO_W-1:0] prio_tab [NUM_IRQ];
  logic              walking;
  logic [9:0]        cur, tgt;

  wire [9:0]    eid     = eoi_wdata[9:0];
  wire          unused_hi = ^eoi_wdata[31:10];
  wire          ack_go  = ack_req && !walking;
  wire          eoi_go  = eoi_req && !ack_req && !walking;
  wire          hp_ok   = (hp_id < NIRQ_ID) && ({1'b0, hp_prio} < run_prio);
  wire [IW-1:0] hp_ix   = hp_id[IW-1:0];
  wire [IW-1:0] run_ix  = run_id[IW-1:0];
  wire [IW-1:0] cur_ix  = cur[IW-1:0];
  wire [IW-1:0] tgt_ix  = tgt[IW-1:0];
  wire [9:0]    run_link = link[run_ix];
  wire [9:0]    cur_nxt  = link[cur_ix];
  wire [PRIO_W:0] back_prio = (run_link == NONE) ? IDLE_PRIO
                                                 : {1'b0, prio_tab[run_link[IW-1:0]]};

  assign busy = walking;

  always_ff @(posedge clk) begin
    if (ack_go && hp_ok) prio_tab[hp_ix] <= hp_prio;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) link[i] <= NONE;
      run_id   <= NONE;
      run_prio <= IDLE_PRIO;
      walking  <= 1'b0;
      cur      <= NONE;
      tgt      <= NONE;
      ack_vld  <= 1'b0;
      ack_id   <= NONE;
      clr_vld  <= 1'b0;
      clr_id   <= NONE;
      clr_all  <= 1'b0;
      set_vld  <= 1'b0;
      set_id   <= NONE;
    end else begin
      ack_vld <= ack_go;
      clr_vld <= 1'b0;
      set_vld <= 1'b0;
      if (ack_go) begin
        if (hp_ok) begin
          ack_id        <= hp_id;
          link[hp_ix]   <= run_id;
          run_id        <= hp_id;
          run_prio      <= {1'b0, hp_prio};
          clr_vld       <= 1'b1;
          clr_id        <= hp_id;
          clr_all       <= hp_model;
        end else begin
          ack_id <= NONE;
        end
      end else if (eoi_go && run_id != NONE) begin
        if (eoi_repend && eid < NIRQ_ID) begin
          set_vld <= 1'b1;
          set_id  <= eid;
        end
        if (eid == run_id) begin
          run_id   <= run_link;
          run_prio <= back_prio;
        end else begin
          walking <= 1'b1;
          cur     <= run_id;
          tgt     <= eid;
        end
      end
      if (walking) begin
        if (cur_nxt == NONE) begin
          walking <= 1'b0;
        end else if (cur_nxt == tgt) begin
          link[cur_ix] <= link[tgt_ix];
          walking      <= 1'b0;
        end else begin
          cur <= cur_nxt;
        end
      end
    end
  end

  p_ack_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_id == NONE) |-> (run_id == $past(run_id)));
  p_ack_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_id != NONE) |-> (run_id == ack_id && run_prio < $past(run_prio)));
  p_idle_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NONE) |-> (run_prio == IDLE_PRIO));
  p_clr_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld |-> (ack_vld && clr_id == ack_id));
  p_eoi_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_go && run_id == NONE) |=> (!set_vld && run_id == NONE));
  p_walk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walking |=> (run_id == $past(run_id)));
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walking |=> (!ack_vld && !set_vld));
  p_ack_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && eoi_req && !walking) |=> (ack_vld && !set_vld));
endmodule

// File: tb/irq_ack_tracker_tb.sv
`timescale 1ns/1ps
module irq_ack_tracker_tb;
  localparam int NIRQ = 64;
  logic clk = 0, rst_n = 0;
  logic [9:0] hp_id = 10'h3FF;
  logic [7:0] hp_prio = 0;
  logic hp_model = 0, ack_req = 0, eoi_req = 0, eoi_repend = 0;
  logic [31:0] eoi_wdata = 0;
  logic ack_vld, busy, clr_vld, clr_all, set_vld;
  logic [9:0] ack_id, run_id, clr_id, set_id;
  logic [8:0] run_prio;

  always #5 clk = ~clk;

  irq_ack_tracker #(.NUM_IRQ(NIRQ), .PRIO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .hp_prio(hp_prio), .hp_model(hp_model),
    .ack_req(ack_req), .ack_vld(ack_vld), .ack_id(ack_id),
    .eoi_req(eoi_req), .eoi_wdata(eoi_wdata), .eoi_repend(eoi_repend), .busy(busy),
    .run_id(run_id), .run_prio(run_prio), .clr_vld(clr_vld), .clr_id(clr_id),
    .clr_all(clr_all), .set_vld(set_vld), .set_id(set_id));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_link[NIRQ];
  int m_prio[NIRQ];
  int m_run, m_rprio, m_busy;
  int e_ack_id, e_clr_id, e_set_id;
  bit e_ack_vld, e_clr_vld, e_clr_all, e_set_vld;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int prio_of(input int id);
    return (id * 29 + 7) & 255;
  endfunction

  task automatic compare();
    check("R3 run_prio", int'(run_prio), m_rprio);
    check("R6 R7 run_id", int'(run_id), m_run);
    check("R10 busy", int'(busy), int'(m_busy > 0));
    check("R2 ack_vld", int'(ack_vld), int'(e_ack_vld));
    if (e_ack_vld) check("R1 R2 ack_id", int'(ack_id), e_ack_id);
    check("R4 clr_vld", int'(clr_vld), int'(e_clr_vld));
    if (e_clr_vld) begin
      check("R4 clr_id", int'(clr_id), e_clr_id);
      check("R4 clr_all", int'(clr_all), int'(e_clr_all));
    end
    check("R8 set_vld", int'(set_vld), int'(e_set_vld));
    if (e_set_vld) check("R8 set_id", int'(set_id), e_set_id);
  endtask

  // reference model: one call per clock, using the inputs currently driven
  task automatic step();
    int eid, k, c, nx;
    e_ack_vld = 0; e_clr_vld = 0; e_set_vld = 0;
    if (m_busy > 0) begin
      m_busy--;
    end else if (ack_req) begin
      e_ack_vld = 1;
      if (int'(hp_id) < NIRQ && int'(hp_prio) < m_rprio) begin
        e_ack_id = int'(hp_id);
        m_link[hp_id] = m_run;
        m_prio[hp_id] = int'(hp_prio);
        m_run = int'(hp_id);
        m_rprio = int'(hp_prio);
        e_clr_vld = 1; e_clr_id = int'(hp_id); e_clr_all = hp_model;
      end else e_ack_id = 1023;
    end else if (eoi_req && m_run != 1023) begin
      eid = int'(eoi_wdata & 32'h3FF);
      if (eoi_repend && eid < NIRQ) begin e_set_vld = 1; e_set_id = eid; end
      if (eid == m_run) begin
        nx = m_link[m_run];
        m_run = nx;
        m_rprio = (nx == 1023) ? 256 : m_prio[nx];
      end else begin
        k = 0; c = m_run;
        while (k <= NIRQ) begin
          nx = m_link[c];
          k++;
          if (nx == 1023) break;
          if (nx == eid) begin m_link[c] = m_link[eid]; break; end
          c = nx;
        end
        m_busy = k;
      end
    end
    @(posedge clk); #1;
    compare();
  endtask

  task automatic cyc(input bit a, input bit e, input int hp, input bit hpm,
                     input logic [31:0] wd, input bit rep);
    ack_req = a; eoi_req = e; hp_id = 10'(hp);
    hp_prio = (hp == 1023) ? 8'h00 : 8'(prio_of(hp)); hp_model = hpm;
    eoi_wdata = wd; eoi_repend = rep;
    step();
    ack_req = 0; eoi_req = 0; eoi_repend = 0;
  endtask

  task automatic ackp(input int hp, input int pr, input bit hpm);
    ack_req = 1; hp_id = 10'(hp); hp_prio = 8'(pr); hp_model = hpm;
    step();
    ack_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NIRQ; i++) begin m_link[i] = 1023; m_prio[i] = 0; end
    m_run = 1023; m_rprio = 256; m_busy = 0; e_ack_id = 1023;
    e_ack_vld = 0; e_clr_vld = 0; e_set_vld = 0; e_clr_all = 0; e_clr_id = 0; e_set_id = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare();                               // R3 R12 reset state
    ackp(1023, 0, 0);                        // R1 nothing pending
    ackp(5, 8'h40, 1);                       // R2 R4 clear for all CPUs
    ackp(9, 8'h40, 0);                       // R1 equal priority refused
    ackp(9, 8'h20, 0);                       // R2 R4 this CPU only
    ackp(12, 8'h10, 0);
    cyc(0, 1, 0, 0, 32'hABCD_0000 | 32'd9, 0); // R7 R9 splice buried 9
    ackp(3, 8'h01, 0);                       // R10 dropped while busy
    idle(1);
    cyc(0, 1, 0, 0, 32'd12, 0);              // R6 back to 5 at 0x40
    ackp(20, 8'h30, 0);
    ackp(21, 8'h08, 0);
    ackp(22, 8'h04, 1);
    cyc(0, 1, 0, 0, 32'd5, 0);               // R7 R10 three-link walk
    idle(3);
    cyc(0, 1, 0, 0, 32'd22, 0);              // R6
    cyc(0, 1, 0, 0, 32'd21, 0);
    cyc(0, 1, 0, 0, 32'd20, 0);              // R12 reset link ends chain
    cyc(0, 1, 0, 0, 32'd7, 1);               // R5 ignored when idle
    ackp(7, 8'h50, 0);
    cyc(0, 1, 0, 0, 32'hFFFF_FC00 | 32'd7, 1); // R8 R9 re-pend
    ackp(3, 8'h60, 0);
    cyc(0, 1, 0, 0, 32'd40, 1);              // R7 not in chain, R8
    idle(1);
    cyc(1, 1, 4, 1, 32'd3, 1);               // R11 ack wins
    ackp(100, 8'h00, 0);                     // R1 out of range ID
    cyc(0, 1, 0, 0, 32'd4, 0);
    cyc(0, 1, 0, 0, 32'd3, 0);
    for (int n = 0; n < 1500; n++) begin
      int r, hp, eid;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = int'(lfsr);
      hp = (r[9:6] == 0) ? 1023 : int'(r[5:2]);
      eid = r[13] ? m_run : int'(r[19:16]);
      cyc(r[0] & r[1], r[10] & ~r[11], hp, r[12],
          {lfsr[31:20], 10'h0, 10'(eid)}, r[21]);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule